// File: doc/BRIEF.md
# Display Controller Command Decoder

This block sits behind the host port of a small grayscale display controller. Every byte from the host arrives with a tag that marks it as a command opcode or as data. The decoder works out how many parameter bytes each opcode needs, which may be none, one, two, fifteen or sixty-four. It gathers those bytes and applies the whole command to a register file of configuration fields in a single cycle. The fields are the column and row address windows, remap bits, start line, display offset, multiplex ratio, display mode, sleep, phase lengths, clock divider, contrast and a gray-level pulse-width table.

A data byte that arrives while no parameters are pending is pixel data. It goes out on a one-cycle RAM-write strobe. The interface can also be locked. While it is locked, every byte is dropped except the lock opcode followed by its unlock value. If a command byte arrives in the middle of a parameter list, the partial command is abandoned and no register changes. All outputs are registered, so a byte presented in one cycle is visible on the outputs after the next rising edge.

Top module: `dcd_top`

## Requirements
- R1: After reset the outputs read as follows:
  - column window 0..63 and row window 0..127;
  - start line 0, offset 0, remap 0x00, clock divider 0x00, contrast 0x7f;
  - multiplex value 127, display mode 0 (normal), sleep 1;
  - phase 1 = 3, phase 2 = 5;
  - gray entry k (GS k, k = 1..15) equals 4*k;
  - unlocked, no RAM write.
- R2: Opcode 0x15 takes two bytes, start then end, and loads the low 6 bits of each into the column window. Opcode 0x75 does the same for the row window using 7-bit fields. Neither window changes until the second byte arrives.
- R3: Opcode 0x92 takes exactly 64 data bytes. None of them reaches the RAM port and none changes a visible register. The next data byte after them is a RAM write.
- R4: Opcode 0xb8 takes 15 bytes. The first byte is GS1 and the last is GS15, and each stores its low 6 bits. The table changes only when the 15th byte arrives. Opcode 0xb7 restores the reset table at once.
- R5: Opcodes 0xa4, 0xa5, 0xa6 and 0xa7 set the display mode to 0 (normal), 1 (all on), 2 (all off) and 3 (inverted). Opcode 0xae sets sleep to 1 and 0xaf sets it to 0.
- R6: Opcode 0xa8 stores its 7-bit parameter N as the multiplex value when N is 15 or more. A smaller N is ignored. Opcodes 0xa1 (start line) and 0xa2 (offset) each store the low 7 bits of one parameter.
- R7: Opcode 0xb1 sets phase 1 from bits 3:0 and phase 2 from bits 7:4 of its parameter. Opcodes 0xb3, 0x81 and 0xa0 store their whole parameter byte as the clock divider, contrast and remap fields.
- R8: Opcode 0xfd followed by 0x13 locks the interface and sets `locked`. While locked, every other byte is dropped: no register change and no RAM write. Only 0xfd followed by 0x12 clears the lock.
- R9: A command byte that arrives while parameters are pending discards the partial command and updates nothing. The new byte is then decoded as a fresh opcode.
- R10: Opcodes that are not listed above behave as no-ops taking no parameters, and 0xe3 is a no-op too. Opcodes 0x82, 0x90, 0x91, 0x93 to 0x96, 0xb2, 0xbb, 0xbc and 0xbe each consume one byte and store nothing. A data byte with nothing pending pulses `ram_wr_valid` for one cycle with the byte on `ram_wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A host byte is present this cycle |
| in_cmd | input | 1 | 1: byte is an opcode, 0: byte is data |
| in_byte | input | 8 | Host byte |
| ram_wr_valid | output | 1 | Pixel data byte strobe |
| ram_wr_data | output | 8 | Pixel data byte |
| locked | output | 1 | Interface lock state |
| col_start | output | 6 | Column window start |
| col_end | output | 6 | Column window end |
| row_start | output | 7 | Row window start |
| row_end | output | 7 | Row window end |
| remap | output | 8 | Remap control bits |
| start_line | output | 7 | Display start line |
| disp_offset | output | 7 | Display vertical offset |
| mux_ratio | output | 7 | Multiplex value (ratio minus one) |
| disp_mode | output | 2 | 0 normal, 1 all on, 2 all off, 3 inverted |
| sleep | output | 1 | Panel sleep state |
| phase1 | output | 4 | Phase 1 length minus one |
| phase2 | output | 4 | Phase 2 length minus one |
| clk_div | output | 8 | Clock divider and oscillator byte |
| contrast | output | 8 | Contrast value |
| gray_table | output | 90 | GS k at bits [6k-1:6k-6], k = 1..15 |

## Verification
Some rules are checked on every cycle:
- no RAM strobe follows a cycle spent locked or with parameters pending;
- the pending count stays between 1 and 64;
- the multiplex value never drops below 15;
- the gray table and window starts hold still in any cycle without a commit.

Other behaviour needs the bench's byte sequences to show it, because the rule is about which value lands where, or about what happens after a sequence of bytes:
- the parameter order within a command;
- the exact 64-byte consumption;
- abort without a side effect;
- the table restore;
- the unlock sequence.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam logic [7:0] OPC_COLWIN   = 8'h15;
  localparam logic [7:0] OPC_ROWWIN   = 8'h75;
  localparam logic [7:0] OPC_CONTRAST = 8'h81;
  localparam logic [7:0] OPC_BULK     = 8'h92;
  localparam logic [7:0] OPC_REMAP    = 8'ha0;
  localparam logic [7:0] OPC_STLINE   = 8'ha1;
  localparam logic [7:0] OPC_OFFSET   = 8'ha2;
  localparam logic [7:0] OPC_MNORM    = 8'ha4;
  localparam logic [7:0] OPC_MALLON   = 8'ha5;
  localparam logic [7:0] OPC_MALLOFF  = 8'ha6;
  localparam logic [7:0] OPC_MINV     = 8'ha7;
  localparam logic [7:0] OPC_MUX      = 8'ha8;
  localparam logic [7:0] OPC_SLEEPON  = 8'hae;
  localparam logic [7:0] OPC_SLEEPOFF = 8'haf;
  localparam logic [7:0] OPC_PHASE    = 8'hb1;
  localparam logic [7:0] OPC_CLKDIV   = 8'hb3;
  localparam logic [7:0] OPC_GRAYDEF  = 8'hb7;
  localparam logic [7:0] OPC_GRAYLOAD = 8'hb8;
  localparam logic [7:0] OPC_NOP      = 8'he3;
  localparam logic [7:0] OPC_LOCK     = 8'hfd;
  localparam logic [7:0] LOCK_SET     = 8'h13;
  localparam logic [7:0] LOCK_CLR     = 8'h12;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_ALL_ON  = 2'd1,
    MODE_ALL_OFF = 2'd2,
    MODE_INVERT  = 2'd3
  } disp_mode_e;
endpackage

// File: rtl/dcd_opclass.sv
module dcd_opclass
  import dcd_pkg::*;
#(
  parameter int BULK_LEN    = 64,
  parameter int GRAY_STEPS  = 15,
  parameter int CNT_W       = $clog2(BULK_LEN + 1)
) (
  input  logic [7:0]       opcode,
  output logic [CNT_W-1:0] plen
);
  always_comb begin
    unique case (opcode)
      OPC_COLWIN, OPC_ROWWIN:  plen = CNT_W'(2);
      OPC_BULK:                plen = CNT_W'(BULK_LEN);
      OPC_GRAYLOAD:            plen = CNT_W'(GRAY_STEPS);
      8'h81, 8'h82, 8'h90, 8'h91, 8'h93, 8'h94, 8'h95, 8'h96,
      8'ha0, 8'ha1, 8'ha2, 8'ha8, 8'hb1, 8'hb2, 8'hb3, 8'hbb,
      8'hbc, 8'hbe, 8'hfd:     plen = CNT_W'(1);
      default:                 plen = '0;
    endcase
  end
endmodule

// File: rtl/dcd_seq.sv
module dcd_seq
  import dcd_pkg::*;
#(
  parameter int BULK_LEN = 64,
  parameter int CNT_W    = $clog2(BULK_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_cmd,
  input  logic [7:0]       in_byte,
  input  logic [CNT_W-1:0] plen,
  output logic             locked,
  output logic             ram_wr_valid,
  output logic [7:0]       ram_wr_data,
  output logic             commit_en,
  output logic [7:0]       commit_op,
  output logic [7:0]       commit_p0,
  output logic [7:0]       commit_last,
  output logic             param_en,
  output logic [CNT_W-1:0] param_idx,
  output logic [7:0]       cur_op
);
  logic             busy_q;
  logic [7:0]       op_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] idx_q;
  logic [7:0]       p0_q;
  logic             cmd_go;
  logic             dat_go;

  always_comb begin
    cmd_go      = in_valid && in_cmd && (!locked || in_byte == OPC_LOCK);
    dat_go      = in_valid && !in_cmd && busy_q;
    commit_en   = (cmd_go && plen == '0) || (dat_go && rem_q == CNT_W'(1));
    commit_op   = cmd_go ? in_byte : op_q;
    commit_p0   = (idx_q == '0) ? in_byte : p0_q;
    commit_last = in_byte;
    param_en    = dat_go;
    param_idx   = idx_q;
    cur_op      = op_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      op_q         <= '0;
      rem_q        <= '0;
      idx_q        <= '0;
      p0_q         <= '0;
      locked       <= 1'b0;
      ram_wr_valid <= 1'b0;
      ram_wr_data  <= '0;
    end else begin
      ram_wr_valid <= 1'b0;
      if (in_valid && in_cmd) begin
        busy_q <= 1'b0;
        rem_q  <= '0;
        if (cmd_go && plen != '0) begin
          busy_q <= 1'b1;
          op_q   <= in_byte;
          rem_q  <= plen;
          idx_q  <= '0;
        end
      end else if (dat_go) begin
        idx_q <= idx_q + CNT_W'(1);
        rem_q <= rem_q - CNT_W'(1);
        if (idx_q == '0) p0_q <= in_byte;
        if (rem_q == CNT_W'(1)) busy_q <= 1'b0;
      end else if (in_valid && !in_cmd && !locked) begin
        ram_wr_valid <= 1'b1;
        ram_wr_data  <= in_byte;
      end
      if (commit_en && commit_op == OPC_LOCK) begin
        if (commit_last == LOCK_SET)      locked <= 1'b1;
        else if (commit_last == LOCK_CLR) locked <= 1'b0;
      end
    end
  end

  AST_LOCK_NO_RAM: assert property (@(posedge clk) disable iff (rst)
    ram_wr_valid |-> !$past(locked)); // R8
  AST_PENDING_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (rem_q != '0 && rem_q <= CNT_W'(BULK_LEN))); // R3
  AST_RAM_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    ram_wr_valid |-> !$past(busy_q)); // R10
endmodule

// File: rtl/dcd_regs.sv
module dcd_regs
  import dcd_pkg::*;
#(
  parameter int COL_W      = 6,
  parameter int ROW_W      = 7,
  parameter int GRAY_STEPS = 15,
  parameter int GRAY_W     = 6,
  parameter int GRAY_DSTEP = 4,
  parameter int MUX_MIN    = 15,
  parameter int CNT_W      = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         commit_en,
  input  logic [7:0]                   commit_op,
  input  logic [7:0]                   commit_p0,
  input  logic [7:0]                   commit_last,
  input  logic                         param_en,
  input  logic [CNT_W-1:0]             param_idx,
  input  logic [7:0]                   cur_op,
  output logic [COL_W-1:0]             col_start,
  output logic [COL_W-1:0]             col_end,
  output logic [ROW_W-1:0]             row_start,
  output logic [ROW_W-1:0]             row_end,
  output logic [7:0]                   remap,
  output logic [ROW_W-1:0]             start_line,
  output logic [ROW_W-1:0]             disp_offset,
  output logic [ROW_W-1:0]             mux_ratio,
  output logic [1:0]                   disp_mode,
  output logic                         sleep,
  output logic [3:0]                   phase1,
  output logic [3:0]                   phase2,
  output logic [7:0]                   clk_div,
  output logic [7:0]                   contrast,
  output logic [GRAY_STEPS*GRAY_W-1:0] gray_flat
);
  localparam int STAGE_N = GRAY_STEPS - 1;

  logic [GRAY_W-1:0] gray_tab [GRAY_STEPS];
  logic [GRAY_W-1:0] stage    [STAGE_N];
  disp_mode_e        mode_q;

  function automatic logic [GRAY_W-1:0] gray_default(input int k);
    return GRAY_W'((k + 1) * GRAY_DSTEP);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGE_N; i++) stage[i] <= '0;
    end else if (param_en && cur_op == OPC_GRAYLOAD &&
                 param_idx < CNT_W'(STAGE_N)) begin
      stage[param_idx] <= commit_last[GRAY_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_start   <= '0;
      col_end     <= '1;
      row_start   <= '0;
      row_end     <= '1;
      remap       <= '0;
      start_line  <= '0;
      disp_offset <= '0;
      mux_ratio   <= '1;
      mode_q      <= MODE_NORMAL;
      sleep       <= 1'b1;
      phase1      <= 4'd3;
      phase2      <= 4'd5;
      clk_div     <= '0;
      contrast    <= 8'h7f;
      for (int i = 0; i < GRAY_STEPS; i++) gray_tab[i] <= gray_default(i);
    end else if (commit_en) begin
      unique case (commit_op)
        OPC_COLWIN: begin
          col_start <= commit_p0[COL_W-1:0];
          col_end   <= commit_last[COL_W-1:0];
        end
        OPC_ROWWIN: begin
          row_start <= commit_p0[ROW_W-1:0];
          row_end   <= commit_last[ROW_W-1:0];
        end
        OPC_CONTRAST: contrast    <= commit_last;
        OPC_REMAP:    remap       <= commit_last;
        OPC_STLINE:   start_line  <= commit_last[ROW_W-1:0];
        OPC_OFFSET:   disp_offset <= commit_last[ROW_W-1:0];
        OPC_MNORM:    mode_q      <= MODE_NORMAL;
        OPC_MALLON:   mode_q      <= MODE_ALL_ON;
        OPC_MALLOFF:  mode_q      <= MODE_ALL_OFF;
        OPC_MINV:     mode_q      <= MODE_INVERT;
        OPC_SLEEPON:  sleep       <= 1'b1;
        OPC_SLEEPOFF: sleep       <= 1'b0;
        OPC_MUX: begin
          if (commit_last[ROW_W-1:0] >= ROW_W'(MUX_MIN))
            mux_ratio <= commit_last[ROW_W-1:0];
        end
        OPC_PHASE: begin
          phase1 <= commit_last[3:0];
          phase2 <= commit_last[7:4];
        end
        OPC_CLKDIV:   clk_div <= commit_last;
        OPC_GRAYDEF: begin
          for (int i = 0; i < GRAY_STEPS; i++) gray_tab[i] <= gray_default(i);
        end
        OPC_GRAYLOAD: begin
          for (int i = 0; i < STAGE_N; i++) gray_tab[i] <= stage[i];
          gray_tab[STAGE_N] <= commit_last[GRAY_W-1:0];
        end
        default: ;
      endcase
    end
  end

  assign disp_mode = mode_q;

  for (genvar g = 0; g < GRAY_STEPS; g++) begin : g_flat
    assign gray_flat[g*GRAY_W +: GRAY_W] = gray_tab[g];
  end

  AST_MUX_FLOOR: assert property (@(posedge clk) disable iff (rst)
    mux_ratio >= ROW_W'(MUX_MIN)); // R6
  AST_GRAY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit_en |=> $stable(gray_flat)); // R4
  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit_en |=> ($stable(col_start) && $stable(row_start))); // R2
endmodule

// File: rtl/dcd_top.sv
module dcd_top #(
  parameter int COL_W      = 6,
  parameter int ROW_W      = 7,
  parameter int GRAY_STEPS = 15,
  parameter int GRAY_W     = 6,
  parameter int GRAY_DSTEP = 4,
  parameter int MUX_MIN    = 15,
  parameter int BULK_LEN   = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic                         in_cmd,
  input  logic [7:0]                   in_byte,
  output logic                         ram_wr_valid,
  output logic [7:0]                   ram_wr_data,
  output logic                         locked,
  output logic [COL_W-1:0]             col_start,
  output logic [COL_W-1:0]             col_end,
  output logic [ROW_W-1:0]             row_start,
  output logic [ROW_W-1:0]             row_end,
  output logic [7:0]                   remap,
  output logic [ROW_W-1:0]             start_line,
  output logic [ROW_W-1:0]             disp_offset,
  output logic [ROW_W-1:0]             mux_ratio,
  output logic [1:0]                   disp_mode,
  output logic                         sleep,
  output logic [3:0]                   phase1,
  output logic [3:0]                   phase2,
  output logic [7:0]                   clk_div,
  output logic [7:0]                   contrast,
  output logic [GRAY_STEPS*GRAY_W-1:0] gray_table
);
  localparam int CNT_W = $clog2(BULK_LEN + 1);

  logic [CNT_W-1:0] plen;
  logic             commit_en;
  logic [7:0]       commit_op;
  logic [7:0]       commit_p0;
  logic [7:0]       commit_last;
  logic             param_en;
  logic [CNT_W-1:0] param_idx;
  logic [7:0]       cur_op;

  dcd_opclass #(.BULK_LEN(BULK_LEN), .GRAY_STEPS(GRAY_STEPS), .CNT_W(CNT_W)) u_cls (
    .opcode (in_byte),
    .plen   (plen)
  );

  dcd_seq #(.BULK_LEN(BULK_LEN), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_cmd       (in_cmd),
    .in_byte      (in_byte),
    .plen         (plen),
    .locked       (locked),
    .ram_wr_valid (ram_wr_valid),
    .ram_wr_data  (ram_wr_data),
    .commit_en    (commit_en),
    .commit_op    (commit_op),
    .commit_p0    (commit_p0),
    .commit_last  (commit_last),
    .param_en     (param_en),
    .param_idx    (param_idx),
    .cur_op       (cur_op)
  );

  dcd_regs #(
    .COL_W(COL_W), .ROW_W(ROW_W), .GRAY_STEPS(GRAY_STEPS), .GRAY_W(GRAY_W),
    .GRAY_DSTEP(GRAY_DSTEP), .MUX_MIN(MUX_MIN), .CNT_W(CNT_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .commit_en   (commit_en),
    .commit_op   (commit_op),
    .commit_p0   (commit_p0),
    .commit_last (commit_last),
    .param_en    (param_en),
    .param_idx   (param_idx),
    .cur_op      (cur_op),
    .col_start   (col_start),
    .col_end     (col_end),
    .row_start   (row_start),
    .row_end     (row_end),
    .remap       (remap),
    .start_line  (start_line),
    .disp_offset (disp_offset),
    .mux_ratio   (mux_ratio),
    .disp_mode   (disp_mode),
    .sleep       (sleep),
    .phase1      (phase1),
    .phase2      (phase2),
    .clk_div     (clk_div),
    .contrast    (contrast),
    .gray_flat   (gray_table)
  );
endmodule

// File: tb/sim_dcd_top.sv
`timescale 1ns/1ps
module sim_dcd_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_cmd = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic ram_wr_valid, locked, sleep;
  logic [7:0] ram_wr_data, remap, clk_div, contrast;
  logic [5:0] col_start, col_end;
  logic [6:0] row_start, row_end, start_line, disp_offset, mux_ratio;
  logic [1:0] disp_mode;
  logic [3:0] phase1, phase2;
  logic [89:0] gray_table;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dcd_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cmd(in_cmd), .in_byte(in_byte),
    .ram_wr_valid(ram_wr_valid), .ram_wr_data(ram_wr_data), .locked(locked),
    .col_start(col_start), .col_end(col_end), .row_start(row_start), .row_end(row_end),
    .remap(remap), .start_line(start_line), .disp_offset(disp_offset),
    .mux_ratio(mux_ratio), .disp_mode(disp_mode), .sleep(sleep), .phase1(phase1),
    .phase2(phase2), .clk_div(clk_div), .contrast(contrast), .gray_table(gray_table)
  );

  // expected state, derived from the requirements
  int e_cs, e_ce, e_rs, e_re, e_remap, e_sl, e_off, e_mux, e_mode, e_sleep;
  int e_p1, e_p2, e_div, e_con, e_lock, e_ramv, e_ramd;
  int e_gray [15];
  int m_busy, m_op, m_rem, m_idx, m_p0;
  int m_stage [15];

  function automatic int plen_of(input int b);
    case (b)
      'h15, 'h75: return 2;
      'h92: return 64;
      'hb8: return 15;
      'h81, 'h82, 'h90, 'h91, 'h93, 'h94, 'h95, 'h96, 'ha0, 'ha1, 'ha2,
      'ha8, 'hb1, 'hb2, 'hb3, 'hbb, 'hbc, 'hbe, 'hfd: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    e_cs = 0; e_ce = 63; e_rs = 0; e_re = 127; e_remap = 0; e_sl = 0; e_off = 0;
    e_mux = 127; e_mode = 0; e_sleep = 1; e_p1 = 3; e_p2 = 5; e_div = 0;
    e_con = 'h7f; e_lock = 0; e_ramv = 0; e_ramd = 0;
    for (int k = 0; k < 15; k++) e_gray[k] = 4 * (k + 1);
    m_busy = 0; m_op = 0; m_rem = 0; m_idx = 0; m_p0 = 0;
  endtask

  task automatic apply(input int op, input int p0, input int last);
    case (op)
      'h15: begin e_cs = p0 & 63; e_ce = last & 63; end
      'h75: begin e_rs = p0 & 127; e_re = last & 127; end
      'h81: e_con = last;
      'ha0: e_remap = last;
      'ha1: e_sl = last & 127;
      'ha2: e_off = last & 127;
      'ha4: e_mode = 0;
      'ha5: e_mode = 1;
      'ha6: e_mode = 2;
      'ha7: e_mode = 3;
      'hae: e_sleep = 1;
      'haf: e_sleep = 0;
      'ha8: if ((last & 127) >= 15) e_mux = last & 127;
      'hb1: begin e_p1 = last & 15; e_p2 = (last >> 4) & 15; end
      'hb3: e_div = last;
      'hb7: for (int k = 0; k < 15; k++) e_gray[k] = 4 * (k + 1);
      'hb8: begin
        for (int k = 0; k < 14; k++) e_gray[k] = m_stage[k];
        e_gray[14] = last & 63;
      end
      'hfd: begin
        if (last == 'h13) e_lock = 1;
        else if (last == 'h12) e_lock = 0;
      end
      default: ;
    endcase
  endtask

  task automatic model(input int c, input int b);
    e_ramv = 0;
    if (c != 0) begin
      m_busy = 0;
      if (e_lock == 0 || b == 'hfd) begin
        int n;
        n = plen_of(b);
        if (n == 0) apply(b, 0, 0);
        else begin m_busy = 1; m_op = b; m_rem = n; m_idx = 0; end
      end
    end else if (m_busy != 0) begin
      if (m_idx == 0) m_p0 = b;
      if (m_op == 'hb8 && m_idx < 14) m_stage[m_idx] = b & 63;
      m_idx++;
      m_rem--;
      if (m_rem == 0) begin m_busy = 0; apply(m_op, m_p0, b); end
    end else if (e_lock == 0) begin
      e_ramv = 1; e_ramd = b;
    end
  endtask

  task automatic chk(input string tag, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [89:0] eg;
    for (int k = 0; k < 15; k++) eg[k*6 +: 6] = 6'(e_gray[k]);
    chk(tag, "col_start", int'(col_start), e_cs);
    chk(tag, "col_end", int'(col_end), e_ce);
    chk(tag, "row_start", int'(row_start), e_rs);
    chk(tag, "row_end", int'(row_end), e_re);
    chk(tag, "remap", int'(remap), e_remap);
    chk(tag, "start_line", int'(start_line), e_sl);
    chk(tag, "disp_offset", int'(disp_offset), e_off);
    chk(tag, "mux_ratio", int'(mux_ratio), e_mux);
    chk(tag, "disp_mode", int'(disp_mode), e_mode);
    chk(tag, "sleep", int'(sleep), e_sleep);
    chk(tag, "phase1", int'(phase1), e_p1);
    chk(tag, "phase2", int'(phase2), e_p2);
    chk(tag, "clk_div", int'(clk_div), e_div);
    chk(tag, "contrast", int'(contrast), e_con);
    chk(tag, "locked", int'(locked), e_lock);
    chk(tag, "ram_wr_valid", int'(ram_wr_valid), e_ramv);
    if (e_ramv != 0) chk(tag, "ram_wr_data", int'(ram_wr_data), e_ramd);
    checks++;
    if (gray_table !== eg) begin
      errors++;
      $display("FAIL %s gray_table actual=%h expected=%h", tag, gray_table, eg);
    end
  endtask

  task automatic send(input int c, input int b, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_cmd = (c != 0);
    in_byte = 8'(b);
    @(posedge clk);
    #1;
    model(c, b);
    check_all(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check_all("R1");

    // R2 windows, with a check between start and end bytes
    send(1, 'h15, "R2"); send(0, 'h05, "R2"); send(0, 'hff, "R2");
    send(1, 'h75, "R2"); send(0, 'h10, "R2"); send(0, 'h7e, "R2");
    // R5 modes and sleep
    send(1, 'ha5, "R5"); send(1, 'ha6, "R5"); send(1, 'ha7, "R5");
    send(1, 'ha4, "R5"); send(1, 'haf, "R5"); send(1, 'hae, "R5");
    // R6 multiplex floor, start line, offset
    send(1, 'ha8, "R6"); send(0, 'h0e, "R6");
    send(1, 'ha8, "R6"); send(0, 'h1f, "R6");
    send(1, 'ha8, "R6"); send(0, 'h0f, "R6");
    send(1, 'ha1, "R6"); send(0, 'h85, "R6");
    send(1, 'ha2, "R6"); send(0, 'h33, "R6");
    // R7 phases, divider, contrast, remap
    send(1, 'hb1, "R7"); send(0, 'h4a, "R7");
    send(1, 'hb3, "R7"); send(0, 'hc1, "R7");
    send(1, 'h81, "R7"); send(0, 'h9c, "R7");
    send(1, 'ha0, "R7"); send(0, 'h56, "R7");
    // R4 gray load and restore
    send(1, 'hb8, "R4");
    for (int i = 0; i < 15; i++) send(0, 3 * i + 65, "R4");
    send(1, 'hb7, "R4");
    // R9 abort of partial gray load and window
    send(1, 'hb8, "R9");
    for (int i = 0; i < 7; i++) send(0, i + 1, "R9");
    send(1, 'h15, "R9"); send(0, 'h21, "R9");
    send(1, 'ha5, "R9");
    send(0, 'h22, "R9");
    // R3 bulk consumption then RAM write
    send(1, 'h92, "R3");
    for (int i = 0; i < 64; i++) send(0, i * 5, "R3");
    send(0, 'h5a, "R3");
    // R8 lock behaviour
    send(1, 'hfd, "R8"); send(0, 'h13, "R8");
    send(0, 'h77, "R8");
    send(1, 'h81, "R8"); send(0, 'h44, "R8");
    send(1, 'ha4, "R8");
    send(1, 'hfd, "R8"); send(0, 'h13, "R8");
    send(1, 'hfd, "R8"); send(0, 'h12, "R8");
    send(0, 'h66, "R8");
    // R10 unknown, no-op, analog one-byte opcodes
    send(1, 'h00, "R10"); send(0, 'h11, "R10");
    send(1, 'he3, "R10"); send(0, 'h12, "R10");
    send(1, 'h91, "R10"); send(0, 'h80, "R10"); send(0, 'h81, "R10");
    idle();
    @(posedge clk);
    #1;
    e_ramv = 0;
    check_all("R10");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 35) begin
        int pick;
        pick = int'($urandom_range(0, 19));
        case (pick)
          0: send(1, 'h15, "RAND");  1: send(1, 'h75, "RAND");
          2: send(1, 'h81, "RAND");  3: send(1, 'ha0, "RAND");
          4: send(1, 'ha1, "RAND");  5: send(1, 'ha2, "RAND");
          6: send(1, 'ha8, "RAND");  7: send(1, 'hb1, "RAND");
          8: send(1, 'hb3, "RAND");  9: send(1, 'hb7, "RAND");
          10: send(1, 'hb8, "RAND"); 11: send(1, 'hfd, "RAND");
          12: send(1, 'hfd, "RAND"); 13: send(1, 'ha4 + int'($urandom_range(0, 3)), "RAND");
          14: send(1, 'hae + int'($urandom_range(0, 1)), "RAND");
          15: send(1, 'he3, "RAND"); 16: send(1, 'h95, "RAND");
          17: if ($urandom_range(0, 9) == 0) send(1, 'h92, "RAND"); else send(1, 'h02, "RAND");
          default: send(1, int'($urandom_range(0, 255)), "RAND");
        endcase
      end else begin
        int d;
        d = int'($urandom_range(0, 5));
        if (d == 0) send(0, 'h12, "RAND");
        else if (d == 1) send(0, 'h13, "RAND");
        else send(0, int'($urandom_range(0, 255)), "RAND");
      end
    end
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule